// File: doc/BRIEF.md
# Parallel I/O Expander Host Register Decoder

This block is the processor-facing register front end of a three-port, byte-wide parallel I/O expander. A host reaches it through a 2-bit address, a byte of write data and three active-low strobes: chip select, read and write. The block passes each host write either into one of three port output latches or into a shared control address. It decodes reads into a byte taken from either the latches or the port pins.

A write to the control address carries one of two commands, told apart by its top bit. The first is a configuration word that sets the mode and direction of each port group. The second is a single-bit set/clear aimed at one bit of the third port. That port's bits double as handshake lines once a group enters a handshake mode. A set/clear aimed at the line that a handshake mode reserves for its interrupt enable writes an internal enable flip-flop and leaves the output latch unchanged. The group controllers that run the handshakes read the direction, mode and enable outputs of this block. Pad drivers and handshake timing sit outside it.

The write strobe is asynchronous to the block clock. It is synchronised, and a write takes effect on the synchronised rising edge of the strobe. Address and data are captured while the strobe is low.

Top module: `ppi_host_decoder`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control address. A write to addresses 0 to 2 loads the byte into `pa_out`, `pb_out` or `pc_out` respectively.
- R2: An access happens only while `cs_n` is low. A write strobed with `cs_n` high changes no latch. A read with `cs_n` high leaves `rdata_oe` at 0 and `rdata` at 0.
- R3: Reset (`rst` high) leaves every direction output at 1 (input), `grpa_mode` at 0, `grpb_mode` at 0, all three output latches at 0 and all interrupt enables at 0. A read of address 3 then returns 8'h9B.
- R4: A control write with bit 7 = 1 is a configuration word, read back unchanged at address 3. Its fields are: bit 6:5 port A mode, bit 4 port A direction, bit 3 port C upper-nibble direction, bit 2 port B mode, bit 1 port B direction, bit 0 port C lower-nibble direction. In every direction field, 1 means input.
- R5: A control write with bit 7 = 0 is a set/clear command. Bits 3:1 give the port C bit index and bit 0 gives the new value. The command changes only that bit of `pc_out`.
- R6: Every configuration word clears `inte_a_in`, `inte_a_out` and `inte_b`.
- R7: A set/clear is redirected to an interrupt enable and leaves `pc_out` unchanged in three cases. Index 2 while port B is in mode 1 goes to `inte_b`. Index 4 while port A is in handshake input goes to `inte_a_in`. Index 6 while port A is in handshake output goes to `inte_a_out`. Any other index, and any index while the group is in mode 0, reaches `pc_out`.
- R8: Port A mode field value 00 gives mode 0 and 01 gives mode 1; any value with bit 6 set gives mode 2, reported as `grpa_mode` = 2. Port B has only modes 0 and 1. In mode 2, indices 4 and 6 are both redirected, and a read of port A returns its pins whatever bit 4 holds.
- R9: A write takes effect on the rising edge of the synchronised write strobe. The latches keep their old value while `wr_n` stays low and for the first clock edge after it rises. They hold the new value after the third clock edge after the rise (two synchroniser stages).
- R10: While `cs_n` and `rd_n` are both low, `rdata_oe` is 1 and `rdata` is driven. A port in input direction returns its pins and a port in output direction returns its latch. Port C makes this choice per nibble. Address 3 returns the stored configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 2 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when not reading |
| rdata_oe | output | 1 | Read data valid / drive enable |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin values |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_dir_in | output | 1 | Port A direction, 1 = input |
| pb_dir_in | output | 1 | Port B direction, 1 = input |
| pcu_dir_in | output | 1 | Port C upper nibble direction, 1 = input |
| pcl_dir_in | output | 1 | Port C lower nibble direction, 1 = input |
| grpa_mode | output | 2 | Port A group mode 0, 1 or 2 |
| grpb_mode | output | 1 | Port B group mode 0 or 1 |
| inte_a_in | output | 1 | Port A input-handshake interrupt enable |
| inte_a_out | output | 1 | Port A output-handshake interrupt enable |
| inte_b | output | 1 | Port B interrupt enable |

## Verification
In one commit cycle, a set/clear command has to be decoded against the mode that the configuration latch holds at that moment. This is where redirection to an enable meets the plain pin update. The bench provokes it by issuing set/clear commands straight after a configuration word, with port A in handshake input, in mode 2 and in mode 0, aiming each command at a reserved index and at a free one. For each command it judges the enable outputs and `pc_out` together: exactly one of them may move. A later configuration word must clear every enable that the commands set.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

    typedef enum logic [1:0] {
        SEL_PA  = 2'b00,
        SEL_PB  = 2'b01,
        SEL_PC  = 2'b10,
        SEL_CTL = 2'b11
    } port_sel_e;

    // control write: top bit picks the command kind
    localparam int CMD_KIND_BIT = 7;
    // configuration word field positions
    localparam int CFG_A_MODE_HI = 6;
    localparam int CFG_A_MODE_LO = 5;
    localparam int CFG_A_DIR     = 4;
    localparam int CFG_CU_DIR    = 3;
    localparam int CFG_B_MODE    = 2;
    localparam int CFG_B_DIR     = 1;
    localparam int CFG_CL_DIR    = 0;
    localparam int CFG_W         = 7;
    localparam logic [CFG_W-1:0] CFG_RESET = 7'h1B;

    // port C lines reserved for interrupt enables in handshake modes
    localparam int IE_B_IDX  = 2;
    localparam int IE_AI_IDX = 4;
    localparam int IE_AO_IDX = 6;

    function automatic logic [1:0] grp_a_mode(input logic [CFG_W-1:0] cfg);
        if (cfg[CFG_A_MODE_HI]) return 2'd2;
        return {1'b0, cfg[CFG_A_MODE_LO]};
    endfunction

endpackage

// File: rtl/ppi_wr_capture.sv
module ppi_wr_capture #(
    parameter int DW          = 8,
    parameter int AW          = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          commit,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data
);
    localparam int SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] wr_sh;
        logic            pend;
        logic [AW-1:0]   a;
        logic [DW-1:0]   d;
    } cap_t;

    cap_t cap_d, cap_q;

    // synchronised strobe is stage SYNC_STAGES-1, its previous value is stage SYNC_STAGES
    assign commit = cap_q.pend && cap_q.wr_sh[SYNC_STAGES-1] && !cap_q.wr_sh[SYNC_STAGES];
    assign c_addr = cap_q.a;
    assign c_data = cap_q.d;

    always_comb begin
        cap_d       = cap_q;
        cap_d.wr_sh = {cap_q.wr_sh[SH_W-2:0], wr_n};
        if (!cs_n && !wr_n) begin
            cap_d.pend = 1'b1;
            cap_d.a    = addr;
            cap_d.d    = wdata;
        end else if (commit) begin
            cap_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q.wr_sh <= '1;
            cap_q.pend  <= 1'b0;
            cap_q.a     <= '0;
            cap_q.d     <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit); // R9

endmodule

// File: rtl/ppi_ctl_regs.sv
module ppi_ctl_regs
    import ppi_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [AW-1:0]    c_addr,
    input  logic [DW-1:0]    c_data,
    output logic [CFG_W-1:0] cfg,
    output logic [DW-1:0]    pa_lat,
    output logic [DW-1:0]    pb_lat,
    output logic [DW-1:0]    pc_lat,
    output logic             ie_a_in,
    output logic             ie_a_out,
    output logic             ie_b
);
    localparam int IDX_W = $clog2(DW);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [DW-1:0]    pa;
        logic [DW-1:0]    pb;
        logic [DW-1:0]    pc;
        logic             ie_ai;
        logic             ie_ao;
        logic             ie_b;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [1:0]       a_mode;
    logic             a_in_hs;
    logic             a_out_hs;
    logic             b_hs;
    logic [IDX_W-1:0] bit_idx;
    logic             bit_val;
    logic             rsv_b, rsv_ai, rsv_ao;
    logic             is_ctl, is_cfg_wr, is_bsr_wr, redirect;

    always_comb begin
        a_mode    = grp_a_mode(regs_q.cfg);
        a_in_hs   = (a_mode == 2'd2) || (a_mode == 2'd1 && regs_q.cfg[CFG_A_DIR]);
        a_out_hs  = (a_mode == 2'd2) || (a_mode == 2'd1 && !regs_q.cfg[CFG_A_DIR]);
        b_hs      = regs_q.cfg[CFG_B_MODE];
        bit_idx   = c_data[IDX_W:1];
        bit_val   = c_data[0];
        rsv_b     = b_hs     && (bit_idx == IDX_W'(IE_B_IDX));
        rsv_ai    = a_in_hs  && (bit_idx == IDX_W'(IE_AI_IDX));
        rsv_ao    = a_out_hs && (bit_idx == IDX_W'(IE_AO_IDX));
        redirect  = rsv_b || rsv_ai || rsv_ao;
        is_ctl    = (port_sel_e'(c_addr) == SEL_CTL);
        is_cfg_wr = commit && is_ctl && c_data[CMD_KIND_BIT];
        is_bsr_wr = commit && is_ctl && !c_data[CMD_KIND_BIT];
    end

    always_comb begin
        regs_d = regs_q;
        if (commit) begin
            case (port_sel_e'(c_addr))
                SEL_PA: regs_d.pa = c_data;
                SEL_PB: regs_d.pb = c_data;
                SEL_PC: regs_d.pc = c_data;
                default: begin
                    if (c_data[CMD_KIND_BIT]) begin
                        regs_d.cfg   = c_data[CFG_W-1:0];
                        regs_d.ie_ai = 1'b0;
                        regs_d.ie_ao = 1'b0;
                        regs_d.ie_b  = 1'b0;
                    end else if (rsv_b) begin
                        regs_d.ie_b = bit_val;
                    end else if (rsv_ai) begin
                        regs_d.ie_ai = bit_val;
                    end else if (rsv_ao) begin
                        regs_d.ie_ao = bit_val;
                    end else begin
                        regs_d.pc[bit_idx] = bit_val;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.cfg   <= CFG_RESET;
            regs_q.pa    <= '0;
            regs_q.pb    <= '0;
            regs_q.pc    <= '0;
            regs_q.ie_ai <= 1'b0;
            regs_q.ie_ao <= 1'b0;
            regs_q.ie_b  <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg      = regs_q.cfg;
    assign pa_lat   = regs_q.pa;
    assign pb_lat   = regs_q.pb;
    assign pc_lat   = regs_q.pc;
    assign ie_a_in  = regs_q.ie_ai;
    assign ie_a_out = regs_q.ie_ao;
    assign ie_b     = regs_q.ie_b;

    AST_CFG_CLEARS_INTE: assert property (@(posedge clk) disable iff (rst)
        is_cfg_wr |=> (!ie_a_in && !ie_a_out && !ie_b)); // R6
    AST_BSR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        is_bsr_wr |=> ($countones(pc_lat ^ $past(pc_lat)) <= 1)); // R5
    AST_REDIRECT_HOLDS_PIN: assert property (@(posedge clk) disable iff (rst)
        (is_bsr_wr && redirect) |=> $stable(pc_lat)); // R7
    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(regs_q)); // R9

endmodule

// File: rtl/ppi_rd_mux.sv
module ppi_rd_mux
    import ppi_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic [AW-1:0]    addr,
    input  logic [CFG_W-1:0] cfg,
    input  logic [DW-1:0]    pa_lat,
    input  logic [DW-1:0]    pb_lat,
    input  logic [DW-1:0]    pc_lat,
    input  logic [DW-1:0]    pa_in,
    input  logic [DW-1:0]    pb_in,
    input  logic [DW-1:0]    pc_in,
    output logic [DW-1:0]    rdata,
    output logic             rdata_oe
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] pc_view;
    logic          a_reads_pins;

    for (genvar i = 0; i < DW; i++) begin : g_pc_bit
        if (i >= HALF) begin : g_upper
            assign pc_view[i] = cfg[CFG_CU_DIR] ? pc_in[i] : pc_lat[i];
        end else begin : g_lower
            assign pc_view[i] = cfg[CFG_CL_DIR] ? pc_in[i] : pc_lat[i];
        end
    end

    assign a_reads_pins = cfg[CFG_A_DIR] || cfg[CFG_A_MODE_HI];
    assign rdata_oe     = !cs_n && !rd_n;

    always_comb begin
        rdata = '0;
        if (rdata_oe) begin
            case (port_sel_e'(addr))
                SEL_PA:  rdata = a_reads_pins ? pa_in : pa_lat;
                SEL_PB:  rdata = cfg[CFG_B_DIR] ? pb_in : pb_lat;
                SEL_PC:  rdata = pc_view;
                default: rdata = DW'({1'b1, cfg});
            endcase
        end
    end

endmodule

// File: rtl/ppi_host_decoder.sv
module ppi_host_decoder
    import ppi_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe,
    input  logic [DW-1:0] pa_in,
    input  logic [DW-1:0] pb_in,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pc_out,
    output logic          pa_dir_in,
    output logic          pb_dir_in,
    output logic          pcu_dir_in,
    output logic          pcl_dir_in,
    output logic [1:0]    grpa_mode,
    output logic          grpb_mode,
    output logic          inte_a_in,
    output logic          inte_a_out,
    output logic          inte_b
);
    localparam int AW = 2;

    logic             commit;
    logic [AW-1:0]    c_addr;
    logic [DW-1:0]    c_data;
    logic [CFG_W-1:0] cfg;

    ppi_wr_capture #(.DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .wdata  (wdata),
        .commit (commit),
        .c_addr (c_addr),
        .c_data (c_data)
    );

    ppi_ctl_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .c_addr   (c_addr),
        .c_data   (c_data),
        .cfg      (cfg),
        .pa_lat   (pa_out),
        .pb_lat   (pb_out),
        .pc_lat   (pc_out),
        .ie_a_in  (inte_a_in),
        .ie_a_out (inte_a_out),
        .ie_b     (inte_b)
    );

    ppi_rd_mux #(.DW(DW), .AW(AW)) u_rd (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .addr     (addr),
        .cfg      (cfg),
        .pa_lat   (pa_out),
        .pb_lat   (pb_out),
        .pc_lat   (pc_out),
        .pa_in    (pa_in),
        .pb_in    (pb_in),
        .pc_in    (pc_in),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    assign pa_dir_in  = cfg[CFG_A_DIR];
    assign pb_dir_in  = cfg[CFG_B_DIR];
    assign pcu_dir_in = cfg[CFG_CU_DIR];
    assign pcl_dir_in = cfg[CFG_CL_DIR];
    assign grpa_mode  = grp_a_mode(cfg);
    assign grpb_mode  = cfg[CFG_B_MODE];

    AST_PORTB_NO_INTE_IN_MODE0: assert property (@(posedge clk) disable iff (rst)
        (!grpb_mode && $stable(grpb_mode)) |=> $stable(inte_b)); // R7

endmodule

// File: tb/ppi_host_decoder_tb.sv
module ppi_host_decoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, pa_out, pb_out, pc_out;
    logic       rdata_oe;
    logic [7:0] pa_in = 8'hA5, pb_in = 8'h3C, pc_in = 8'hF0;
    logic       pa_dir_in, pb_dir_in, pcu_dir_in, pcl_dir_in;
    logic [1:0] grpa_mode;
    logic       grpb_mode, inte_a_in, inte_a_out, inte_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ppi_host_decoder u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
        .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
        .pa_dir_in(pa_dir_in), .pb_dir_in(pb_dir_in),
        .pcu_dir_in(pcu_dir_in), .pcl_dir_in(pcl_dir_in),
        .grpa_mode(grpa_mode), .grpb_mode(grpb_mode),
        .inte_a_in(inte_a_in), .inte_a_out(inte_a_out), .inte_b(inte_b)
    );

    // row: {is_read, req, addr, wdata, expected rdata}
    localparam int NV = 25;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 4'd3,  2'd3, 8'h00, 8'h9B},  // R3 reset config readback
        {1'b1, 4'd10, 2'd0, 8'h00, 8'hA5},  // R10 input port A reads pins
        {1'b1, 4'd10, 2'd1, 8'h00, 8'h3C},
        {1'b1, 4'd10, 2'd2, 8'h00, 8'hF0},
        {1'b0, 4'd4,  2'd3, 8'h80, 8'h00},  // R4 all outputs, mode 0
        {1'b1, 4'd4,  2'd3, 8'h00, 8'h80},
        {1'b0, 4'd1,  2'd0, 8'h5A, 8'h00},  // R1 port A latch
        {1'b1, 4'd1,  2'd0, 8'h00, 8'h5A},
        {1'b0, 4'd1,  2'd1, 8'hC3, 8'h00},
        {1'b1, 4'd1,  2'd1, 8'h00, 8'hC3},
        {1'b0, 4'd1,  2'd2, 8'h00, 8'h00},
        {1'b1, 4'd1,  2'd2, 8'h00, 8'h00},
        {1'b0, 4'd5,  2'd3, 8'h0F, 8'h00},  // R5 set bit 7
        {1'b1, 4'd5,  2'd2, 8'h00, 8'h80},
        {1'b0, 4'd5,  2'd3, 8'h05, 8'h00},  // R5 set bit 2 (mode 0: not reserved)
        {1'b1, 4'd5,  2'd2, 8'h00, 8'h84},
        {1'b0, 4'd5,  2'd3, 8'h0E, 8'h00},  // R5 clear bit 7
        {1'b1, 4'd5,  2'd2, 8'h00, 8'h04},
        {1'b0, 4'd4,  2'd3, 8'h88, 8'h00},  // R4 upper nibble input
        {1'b1, 4'd10, 2'd2, 8'h00, 8'hF4},  // R10 mixed nibbles
        {1'b0, 4'd4,  2'd3, 8'h89, 8'h00},
        {1'b1, 4'd10, 2'd2, 8'h00, 8'hF0},
        {1'b0, 4'd4,  2'd3, 8'h92, 8'h00},  // A and B inputs
        {1'b1, 4'd10, 2'd0, 8'h00, 8'hA5},
        {1'b1, 4'd10, 2'd1, 8'h00, 8'h3C}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic sel, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = ~sel; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic host_rd(input logic sel, input logic [1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; cs_n = ~sel; rd_n = 1'b0;
        #2;
        d = rdata; oe = rdata_oe;
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic chk_reset_state();
        chk("R3", {pa_dir_in, pb_dir_in, pcu_dir_in, pcl_dir_in}, 8'h0F);
        chk("R3", {grpa_mode, grpb_mode}, 8'h00);
        chk("R3", {inte_a_in, inte_a_out, inte_b}, 8'h00);
        chk("R3", pa_out | pb_out | pc_out, 8'h00);
        chk("R3", {7'b0, rdata_oe}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        logic       oe;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_reset_state();

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][22]) begin
                host_rd(1'b1, VEC[i][17:16], rd, oe);
                n_chk++;
                if (rd !== VEC[i][7:0] || oe !== 1'b1) begin
                    n_fail++;
                    $display("FAIL R%0d row %0d: actual %h expected %h",
                             VEC[i][21:18], i, rd, VEC[i][7:0]);
                end
            end else begin
                host_wr(1'b1, VEC[i][17:16], VEC[i][15:8]);
            end
        end

        // R2: write and read without chip select
        host_wr(1'b0, 2'd0, 8'h11);
        chk("R2", pa_out, 8'h5A);
        host_rd(1'b0, 2'd0, rd, oe);
        chk("R2", rd, 8'h00);
        chk("R2", {7'b0, oe}, 8'h00);

        // R9: commit only after synchronised rising edge
        @(negedge clk);
        addr = 2'd1; wdata = 8'h77; cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", pb_out, 8'hC3);
        wr_n = 1'b1;
        @(negedge clk);
        chk("R9", pb_out, 8'hC3);
        repeat (2) @(negedge clk);
        chk("R9", pb_out, 8'h77);
        cs_n = 1'b1;

        // R7: redirection with port A handshake input, port B handshake
        host_wr(1'b1, 2'd2, 8'h00);
        host_wr(1'b1, 2'd3, 8'hB4);
        chk("R4", {grpa_mode, grpb_mode, pa_dir_in, pb_dir_in}, 8'b0000_1110);
        host_wr(1'b1, 2'd3, 8'h09);
        chk("R7", {inte_a_in, inte_a_out, inte_b}, 8'b100);
        chk("R7", pc_out, 8'h00);
        host_wr(1'b1, 2'd3, 8'h05);
        chk("R7", {inte_a_in, inte_a_out, inte_b}, 8'b101);
        chk("R7", pc_out, 8'h00);
        host_wr(1'b1, 2'd3, 8'h0D);
        chk("R7", {inte_a_in, inte_a_out, inte_b}, 8'b101);
        chk("R7", pc_out, 8'h40);
        host_wr(1'b1, 2'd3, 8'hB4);
        chk("R6", {inte_a_in, inte_a_out, inte_b}, 8'b000);

        // R8: mode 2 reserves both port A enable lines
        host_wr(1'b1, 2'd3, 8'hC0);
        chk("R8", {6'b0, grpa_mode}, 8'h02);
        host_wr(1'b1, 2'd3, 8'h0D);
        chk("R8", {inte_a_in, inte_a_out, inte_b}, 8'b010);
        host_wr(1'b1, 2'd3, 8'h09);
        chk("R8", {inte_a_in, inte_a_out, inte_b}, 8'b110);
        chk("R8", pc_out, 8'h40);
        host_rd(1'b1, 2'd0, rd, oe);
        chk("R8", rd, 8'hA5);
        host_wr(1'b1, 2'd3, 8'hE0);
        chk("R8", {6'b0, grpa_mode}, 8'h02);
        chk("R6", {inte_a_in, inte_a_out, inte_b}, 8'b000);
        host_rd(1'b1, 2'd3, rd, oe);
        chk("R4", rd, 8'hE0);

        // R3: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_reset_state();
        host_rd(1'b1, 2'd3, rd, oe);
        chk("R3", rd, 8'h9B);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule